// File: doc/BRIEF.md
# Converter Result Conditioner

This block sits between a command decoder and a 10-bit analog-to-digital converter. A request for channel 0 or channel 1 launches exactly one conversion through a start/done handshake. When the converter returns its raw code, the block conditions it for transmission.

Conditioning has two parts. A valid code is clamped into a narrow window that stays clear of both rails. A fixed error code replaces the value in two cases: the converter flags an internal fault, or a general-purpose pin that is set up as an input reads high when the conversion starts.

The conditioned word is held, together with a ready flag, until the logic that forms the response loads it. That load happens on the bus command that follows the request, never on the request itself.

Top module: `adc_result_conditioner`

## Requirements
- R1: A strobe with `cmd_kind` 2'b01 (channel 0) or 2'b10 (channel 1), taken while no conversion is pending, raises `conv_start` for exactly one cycle, in the cycle after the strobe. In that same cycle `conv_chan` shows the channel: 0 for 2'b01 and 1 for 2'b10.
- R2: These strobes never raise `conv_start`: a strobe with `cmd_kind` 2'b00 or 2'b11, and any strobe that arrives while a conversion is pending.
- R3: A raw code below 0x020 is reported as 0x020. A raw code above 0x3E3 is reported as 0x3E3. Any other raw code is reported unchanged.
- R4: When `conv_fault` is high together with `conv_done`, the reported word is 0x3F8, whatever the raw code.
- R5: If `io1_dir_out` is 0 and `io1_level` is 1 in the strobe cycle that starts a conversion, the word is 0x3F8. The pin is sampled only in that cycle, so later changes to it have no effect on that conversion.
- R6: If `io1_dir_out` is 1, or the pin is low in the starting strobe cycle, the clamped value of R3 is reported. The level of an output-configured pin makes no difference.
- R7: `result_ready` and the new `result_word` appear in the cycle after `conv_done` is accepted. `result_ready` stays high until `resp_load` is seen and drops in the cycle after that. `result_word` keeps its value after the load.
- R8: A `conv_done` that arrives while no conversion is pending changes neither `result_word` nor `result_ready`.
- R9: While reset is held, `conv_start`, `conv_chan`, `result_ready` and `result_word` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_strobe | input | 1 | A decoded command is present this cycle |
| cmd_kind | input | 2 | Command class: 01 = request channel 0, 10 = request channel 1, other values = other commands |
| io1_dir_out | input | 1 | General-purpose pin 1 is configured as an output |
| io1_level | input | 1 | Logic level of general-purpose pin 1 |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 1 | Channel selected for the converter |
| conv_done | input | 1 | Converter has finished; raw code and fault flag are valid |
| conv_raw | input | W | Raw converter code |
| conv_fault | input | 1 | Converter reports an internal fault |
| resp_load | input | 1 | Response word has been taken for transmission |
| result_word | output | W | Conditioned result |
| result_ready | output | 1 | A new conditioned result is waiting to be sent |

## Verification
On every cycle, the assertions check these properties: the start pulse is one cycle wide and appears only after a valid request while idle; a ready word always lies inside the clamp window or equals the error code; a fault always produces the error code; the ready flag follows the accept and load events; and the word never moves while idle. Only the bench's scenarios can show the rest. That covers the exact clamped value for every raw code, the pin-driven substitution under each combination of direction and level, and the fact that the pin is sampled only at the start of a conversion. The bench sweeps all 1024 raw codes across all four pin configurations, then repeats the boundary codes with the fault flag set.

// File: rtl/adc_result_conditioner.sv
module adc_result_conditioner #(
  parameter int unsigned W        = 10,
  parameter int unsigned CODE_LO  = 'h020,
  parameter int unsigned CODE_HI  = 'h3E3,
  parameter int unsigned CODE_ERR = 'h3F8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_strobe,
  input  logic [1:0]   cmd_kind,
  input  logic         io1_dir_out,
  input  logic         io1_level,
  output logic         conv_start,
  output logic         conv_chan,
  input  logic         conv_done,
  input  logic [W-1:0] conv_raw,
  input  logic         conv_fault,
  input  logic         resp_load,
  output logic [W-1:0] result_word,
  output logic         result_ready
);

  localparam logic [W-1:0] LO  = W'(CODE_LO);
  localparam logic [W-1:0] HI  = W'(CODE_HI);
  localparam logic [W-1:0] ERR = W'(CODE_ERR);

  logic         busy, force_err;
  logic [W-1:0] clamped;

  wire is_req = (cmd_kind == 2'b01) || (cmd_kind == 2'b10);
  wire accept = cmd_strobe && is_req && !busy;
  wire finish = busy && conv_done;

  assign clamped = (conv_raw < LO) ? LO : (conv_raw > HI) ? HI : conv_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      force_err    <= 1'b0;
      conv_start   <= 1'b0;
      conv_chan    <= 1'b0;
      result_word  <= '0;
      result_ready <= 1'b0;
    end else begin
      conv_start <= accept;
      if (accept) begin
        busy      <= 1'b1;
        conv_chan <= cmd_kind[1];
        force_err <= !io1_dir_out && io1_level;
      end
      if (finish) begin
        busy         <= 1'b0;
        result_word  <= (conv_fault || force_err) ? ERR : clamped;
        result_ready <= 1'b1;
      end else if (resp_load) begin
        result_ready <= 1'b0;
      end
    end
  end

endmodule

module adc_result_conditioner_chk #(
  parameter int unsigned W        = 10,
  parameter int unsigned CODE_LO  = 'h020,
  parameter int unsigned CODE_HI  = 'h3E3,
  parameter int unsigned CODE_ERR = 'h3F8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_strobe,
  input logic [1:0]   cmd_kind,
  input logic         conv_start,
  input logic         conv_done,
  input logic         conv_fault,
  input logic         resp_load,
  input logic [W-1:0] result_word,
  input logic         result_ready,
  input logic         busy
);
  localparam logic [W-1:0] LO  = W'(CODE_LO);
  localparam logic [W-1:0] HI  = W'(CODE_HI);
  localparam logic [W-1:0] ERR = W'(CODE_ERR);

  p_start_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_other_cmd_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && (cmd_kind == 2'b00 || cmd_kind == 2'b11)) |=> !conv_start);

  p_busy_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !conv_start);

  p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_ready |-> (result_word == ERR) || (result_word >= LO && result_word <= HI));

  p_fault_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_done && conv_fault) |=> (result_word == ERR));

  p_ready_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_done) |=> result_ready);

  p_ready_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_load && !(busy && conv_done)) |=> !result_ready);

  p_idle_word_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result_word));
endmodule

bind adc_result_conditioner adc_result_conditioner_chk #(
  .W(W), .CODE_LO(CODE_LO), .CODE_HI(CODE_HI), .CODE_ERR(CODE_ERR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_kind(cmd_kind),
  .conv_start(conv_start), .conv_done(conv_done), .conv_fault(conv_fault),
  .resp_load(resp_load), .result_word(result_word),
  .result_ready(result_ready), .busy(busy)
);

// File: tb/test_adc_result_conditioner.sv
module test_adc_result_conditioner;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_strobe = 1'b0;
  logic [1:0]   cmd_kind = 2'b00;
  logic         io1_dir_out = 1'b0;
  logic         io1_level = 1'b0;
  logic         conv_start, conv_chan;
  logic         conv_done = 1'b0;
  logic [W-1:0] conv_raw = '0;
  logic         conv_fault = 1'b0;
  logic         resp_load = 1'b0;
  logic [W-1:0] result_word;
  logic         result_ready;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_result_conditioner i_adc_result_conditioner (
    .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_kind(cmd_kind),
    .io1_dir_out(io1_dir_out), .io1_level(io1_level),
    .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_raw(conv_raw), .conv_fault(conv_fault),
    .resp_load(resp_load), .result_word(result_word), .result_ready(result_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int expect_word(int raw, bit dir_out, bit lvl, bit fault);
    if (fault || (!dir_out && lvl)) return 'h3F8;
    if (raw < 'h020) return 'h020;
    if (raw > 'h3E3) return 'h3E3;
    return raw;
  endfunction

  task automatic do_conv(input int raw, input bit dir_out, input bit lvl,
                         input bit fault, input logic [1:0] kind);
    int exp;
    exp = expect_word(raw, dir_out, lvl, fault);
    @(negedge clk);
    cmd_strobe = 1'b1; cmd_kind = kind; io1_dir_out = dir_out; io1_level = lvl;
    @(negedge clk);
    cmd_strobe = 1'b0; io1_level = ~lvl;
    chk(conv_start == 1'b1, "R1 start", int'(conv_start), 1);
    chk(conv_chan == kind[1], "R1 chan", int'(conv_chan), int'(kind[1]));
    @(negedge clk);
    chk(conv_start == 1'b0, "R1 pulse width", int'(conv_start), 0);
    conv_done = 1'b1; conv_raw = W'(raw); conv_fault = fault;
    @(negedge clk);
    conv_done = 1'b0; conv_fault = 1'b0;
    chk(result_ready == 1'b1, "R7 ready", int'(result_ready), 1);
    if (fault)
      chk(int'(result_word) == exp, "R4 fault code", int'(result_word), exp);
    else if (!dir_out && lvl)
      chk(int'(result_word) == exp, "R5 pin error", int'(result_word), exp);
    else
      chk(int'(result_word) == exp, "R3 R6 clamp", int'(result_word), exp);
    resp_load = 1'b1;
    @(negedge clk);
    resp_load = 1'b0;
    chk(result_ready == 1'b0, "R7 cleared", int'(result_ready), 0);
    chk(int'(result_word) == exp, "R7 word held", int'(result_word), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    chk(conv_start == 1'b0, "R9 start", int'(conv_start), 0);
    chk(conv_chan == 1'b0, "R9 chan", int'(conv_chan), 0);
    chk(result_ready == 1'b0, "R9 ready", int'(result_ready), 0);
    chk(result_word == '0, "R9 word", int'(result_word), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int raw = 0; raw < 1024; raw++)
      for (int cfg = 0; cfg < 4; cfg++)
        do_conv(raw, cfg[1], cfg[0], 1'b0, raw[0] ? 2'b10 : 2'b01);

    foreach (held_vals[i]) do_conv(held_vals[i], 1'b1, 1'b0, 1'b1, 2'b01);
    do_conv('h1FF, 1'b0, 1'b0, 1'b1, 2'b10);

    for (int k = 0; k < 4; k = k + 3) begin
      @(negedge clk);
      cmd_strobe = 1'b1; cmd_kind = 2'(k);
      @(negedge clk);
      cmd_strobe = 1'b0;
      chk(conv_start == 1'b0, "R2 other command", int'(conv_start), 0);
    end

    held = int'(result_word);
    @(negedge clk);
    conv_done = 1'b1; conv_raw = 10'h100;
    @(negedge clk);
    conv_done = 1'b0;
    chk(int'(result_word) == held, "R8 idle done word", int'(result_word), held);
    chk(result_ready == 1'b0, "R8 idle done ready", int'(result_ready), 0);

    cmd_strobe = 1'b1; cmd_kind = 2'b01; io1_dir_out = 1'b1;
    @(negedge clk);
    cmd_strobe = 1'b1; cmd_kind = 2'b10;
    chk(conv_start == 1'b1, "R1 start busy test", int'(conv_start), 1);
    @(negedge clk);
    cmd_strobe = 1'b0;
    chk(conv_start == 1'b0, "R2 busy request", int'(conv_start), 0);
    chk(conv_chan == 1'b0, "R2 busy chan kept", int'(conv_chan), 0);
    conv_done = 1'b1; conv_raw = 10'h3E4;
    @(negedge clk);
    conv_done = 1'b0;
    repeat (5) @(negedge clk);
    chk(result_ready == 1'b1, "R7 ready held", int'(result_ready), 1);
    chk(result_word == 10'h3E3, "R3 upper clamp", int'(result_word), 'h3E3);
    resp_load = 1'b1;
    @(negedge clk);
    resp_load = 1'b0;
    chk(result_ready == 1'b0, "R7 load clears", int'(result_ready), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  int held_vals[7] = '{'h000, 'h01F, 'h020, 'h200, 'h3E3, 'h3E4, 'h3FF};
endmodule